// File: doc/BRIEF.md
# CRC Subframe Codeword Generator

The block turns a serial message into a serial codeword for a matching CRC checker. A frame holds `NUM_SUB` subframes of `SUB_LEN` message bits each. Every message bit is forwarded unchanged on the codeword output one cycle after it is accepted. After the last bit of each subframe, the block emits a `CRC_W`-bit checksum over that subframe, most significant bit first.

The checksum can be formed in two ways. In direct mode the register is updated as the message passes through it. In indirect mode the message is shifted in at the low end and then flushed with `CRC_W` zeros, which is long division of the message times x^CRC_W. The generator polynomial, the start value of the register, byte-wise input reflection, checksum reflection and a final XOR mask are all fixed at build time. They must match the settings of the checker. While a checksum is being emitted, `ready_o` is low. A source that holds its bit during that time loses nothing.

A frame begins with a bit accepted while `sof_i` is high. Bits that arrive outside a frame are dropped.

Top module: `crc_gen`

## Requirements
- R1: After reset, `code_valid_o` is 0 and `ready_o` is 1.
- R2: A message bit accepted (`valid_i` and `ready_o` high) inside a frame appears unchanged on `code_o`, with `code_valid_o` high, on the next cycle. Message bits keep their arrival order.
- R3: The cycle after the output of the last message bit of a subframe, the `CRC_W` checksum bits appear on consecutive cycles, most significant bit first.
- R4: `ready_o` is low for exactly `CRC_W` consecutive cycles per subframe, covering the checksum emission. A bit held on the input during that time is accepted afterwards.
- R5: Direct mode (`DIRECT`=1) works per bit. Let f = (top register bit) XOR (message bit). The register shifts left with 0 entering, and is then XORed with `POLY` when f is 1. `POLY` is the polynomial without its leading term, with bit i the coefficient of x^i.
- R6: Indirect mode (`DIRECT`=0) shifts each bit in at bit 0 and XORs with `POLY` when the bit shifted out at the top was 1. After the subframe, `CRC_W` zero bits are shifted in the same way.
- R7: The register is loaded with `INIT` at the first bit of every subframe. Equal subframes therefore give equal checksums.
- R8: With `REFLECT_IN`=1, each group of 8 message bits enters the register in reverse arrival order. This applies to the register only; the forwarded message bits are not reordered. `SUB_LEN` must be a multiple of 8.
- R9: The emitted checksum is the register result, bit-reversed when `REFLECT_OUT`=1, and then XORed with `FINAL_XOR`.
- R10: An accepted bit with `sof_i` low while no frame is open produces no output.
- R11: An accepted bit with `sof_i` high always starts a new frame at subframe 0, bit 0. Any partial subframe is abandoned without a checksum.
- R12: After the checksum of the last subframe the frame is closed, and further bits without `sof_i` are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Message bit present |
| sof_i | input | 1 | Marks the first bit of a frame |
| data_i | input | 1 | Message bit |
| ready_o | output | 1 | Low while a checksum is emitted |
| code_o | output | 1 | Codeword bit |
| code_valid_o | output | 1 | Codeword bit present |

## Verification
Two builds are driven. One uses a 16-bit direct configuration with a non-zero start value and mask. The other uses an 8-bit indirect configuration with both reflections. Both receive all-zero, all-one and random subframes, with random idle gaps and with bits held across every stall. All-zero data exposes the start value and mask alone. Identical subframes show that the register is reloaded for each subframe, and random data separates the polynomial, the bit order and the reflections. Bits sent before a frame and after a frame show that dropping works, and a frame cut short by a new start shows the restart.

// File: rtl/crc_gen_pkg.sv
package crc_gen_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_EMIT} crc_state_e;
endpackage

// File: rtl/crc_gen_ctrl.sv
module crc_gen_ctrl
  import crc_gen_pkg::*;
#(
  parameter int SUB_LEN = 32,
  parameter int NUM_SUB = 2,
  parameter int CRC_W   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  output logic ready_o,
  output logic take_o,
  output logic first_o,
  output logic last_o,
  output logic byte_end_o,
  output logic emit_o,
  output logic active_o
);
  localparam int BW = $clog2(SUB_LEN + 1);
  localparam int SW = $clog2(NUM_SUB + 1);
  localparam int EW = $clog2(CRC_W + 1);

  crc_state_e    state_q;
  logic [BW-1:0] bit_q, idx;
  logic [SW-1:0] sub_q, sub_eff;
  logic [EW-1:0] emit_q;
  logic          acc, start;

  assign ready_o    = (state_q != ST_EMIT);
  assign acc        = valid_i && ready_o;
  assign start      = acc && sof_i;
  assign take_o     = acc && (sof_i || state_q == ST_DATA);
  assign idx        = start ? '0 : bit_q;
  assign sub_eff    = start ? '0 : sub_q;
  assign first_o    = take_o && (idx == '0);
  assign last_o     = take_o && (idx == BW'(SUB_LEN - 1));
  assign byte_end_o = take_o && ((32'(idx) % 8) == 7);
  assign emit_o     = (state_q == ST_EMIT);
  assign active_o   = (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sub_q   <= '0;
      emit_q  <= '0;
    end else if (take_o) begin
      sub_q <= sub_eff;
      if (last_o) begin
        bit_q   <= '0;
        emit_q  <= '0;
        state_q <= ST_EMIT;
      end else begin
        bit_q   <= idx + BW'(1);
        state_q <= ST_DATA;
      end
    end else if (emit_o) begin
      emit_q <= emit_q + EW'(1);
      if (emit_q == EW'(CRC_W - 1)) begin
        if (sub_q == SW'(NUM_SUB - 1)) begin
          sub_q   <= '0;
          state_q <= ST_IDLE;
        end else begin
          sub_q   <= sub_q + SW'(1);
          state_q <= ST_DATA;
        end
      end
    end
  end
endmodule

// File: rtl/crc_gen_lfsr.sv
module crc_gen_lfsr #(
  parameter int               CRC_W       = 16,
  parameter logic [CRC_W-1:0] POLY        = 16'h1021,
  parameter logic [CRC_W-1:0] INIT        = '0,
  parameter logic [CRC_W-1:0] FINAL_XOR   = '0,
  parameter bit               DIRECT      = 1'b1,
  parameter bit               REFLECT_IN  = 1'b0,
  parameter bit               REFLECT_OUT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic first_i,
  input  logic last_i,
  input  logic byte_end_i,
  input  logic data_i,
  input  logic emit_i,
  output logic chk_bit_o
);
  logic [CRC_W-1:0] crc_q, base, nxt, chk_q;

  function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] s, input logic b);
    logic             fb;
    logic [CRC_W-1:0] n;
    if (DIRECT) begin
      fb = s[CRC_W-1] ^ b;
      n  = {s[CRC_W-2:0], 1'b0};
    end else begin
      fb = s[CRC_W-1];
      n  = {s[CRC_W-2:0], b};
    end
    return fb ? (n ^ POLY) : n;
  endfunction

  function automatic logic [CRC_W-1:0] finish(input logic [CRC_W-1:0] s);
    logic [CRC_W-1:0] c, r;
    c = s;
    if (!DIRECT)
      for (int i = 0; i < CRC_W; i++) c = step(c, 1'b0);  // augmentation zeros
    r = c;
    if (REFLECT_OUT)
      for (int i = 0; i < CRC_W; i++) r[i] = c[CRC_W-1-i];
    return r ^ FINAL_XOR;
  endfunction

  assign base = first_i ? INIT : crc_q;

  generate
    if (REFLECT_IN) begin : g_refl
      logic [6:0] byte_q;
      always_comb begin
        nxt = base;
        if (byte_end_i) begin
          nxt = step(nxt, data_i);  // newest bit first
          for (int j = 0; j < 7; j++) nxt = step(nxt, byte_q[j]);
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     byte_q <= '0;
        else if (take_i) byte_q <= {byte_q[5:0], data_i};
      end
    end else begin : g_bit
      logic unused_be;
      assign unused_be = byte_end_i;
      assign nxt = step(base, data_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
      chk_q <= '0;
    end else begin
      if (take_i) crc_q <= nxt;
      if (take_i && last_i) chk_q <= finish(nxt);
      else if (emit_i)      chk_q <= {chk_q[CRC_W-2:0], 1'b0};
    end
  end

  assign chk_bit_o = chk_q[CRC_W-1];
endmodule

// File: rtl/crc_gen.sv
module crc_gen #(
  parameter int               CRC_W       = 16,
  parameter logic [CRC_W-1:0] POLY        = 16'h1021,
  parameter logic [CRC_W-1:0] INIT        = '0,
  parameter logic [CRC_W-1:0] FINAL_XOR   = '0,
  parameter int               SUB_LEN     = 32,
  parameter int               NUM_SUB     = 2,
  parameter bit               DIRECT      = 1'b1,
  parameter bit               REFLECT_IN  = 1'b0,
  parameter bit               REFLECT_OUT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic data_i,
  output logic ready_o,
  output logic code_o,
  output logic code_valid_o
);
  logic take, first, last, byte_end, emit, frame_active, chk_bit;

  crc_gen_ctrl #(
    .SUB_LEN(SUB_LEN), .NUM_SUB(NUM_SUB), .CRC_W(CRC_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .valid_i, .sof_i, .ready_o,
    .take_o(take), .first_o(first), .last_o(last), .byte_end_o(byte_end),
    .emit_o(emit), .active_o(frame_active)
  );

  crc_gen_lfsr #(
    .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT), .FINAL_XOR(FINAL_XOR),
    .DIRECT(DIRECT), .REFLECT_IN(REFLECT_IN), .REFLECT_OUT(REFLECT_OUT)
  ) u_lfsr (
    .clk_i, .rst_ni, .take_i(take), .first_i(first), .last_i(last),
    .byte_end_i(byte_end), .data_i, .emit_i(emit), .chk_bit_o(chk_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o       <= 1'b0;
      code_valid_o <= 1'b0;
    end else begin
      code_valid_o <= take || emit;
      if (take)      code_o <= data_i;
      else if (emit) code_o <= chk_bit;
    end
  end
endmodule

// File: rtl/crc_gen_chk.sv
module crc_gen_chk #(
  parameter int CRC_W = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic sof_i,
  input logic data_i,
  input logic ready_o,
  input logic code_o,
  input logic code_valid_o,
  input logic active_i
);
  localparam int LW = $clog2(CRC_W + 2);
  logic [LW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_q <= '0;
    else if (ready_o) low_q <= '0;
    else              low_q <= low_q + LW'(1);
  end

  p_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!code_valid_o && ready_o));

  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && (sof_i || active_i)) |=> (code_valid_o && code_o == $past(data_i)));

  p_emit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> code_valid_o);

  p_stall_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_q == LW'(CRC_W)));

  p_stall_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (low_q < LW'(CRC_W)));

  p_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && !sof_i && !active_i) |=> !code_valid_o);
endmodule

bind crc_gen crc_gen_chk #(.CRC_W(CRC_W)) u_chk (
  .clk_i, .rst_ni, .valid_i, .sof_i, .data_i, .ready_o, .code_o, .code_valid_o,
  .active_i(frame_active)
);

// File: tb/crc_gen_test.sv
module crc_gen_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic v0 = 0, s0 = 0, d0 = 0, rdy0, co0, cv0;
  logic v1 = 0, s1 = 0, d1 = 0, rdy1, co1, cv1;

  crc_gen #(
    .CRC_W(16), .POLY(16'h1021), .INIT(16'hFFFF), .FINAL_XOR(16'h0F0F),
    .SUB_LEN(16), .NUM_SUB(3), .DIRECT(1'b1), .REFLECT_IN(1'b0), .REFLECT_OUT(1'b0)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(v0), .sof_i(s0), .data_i(d0),
    .ready_o(rdy0), .code_o(co0), .code_valid_o(cv0)
  );

  crc_gen #(
    .CRC_W(8), .POLY(8'h07), .INIT(8'h5A), .FINAL_XOR(8'hA5),
    .SUB_LEN(16), .NUM_SUB(2), .DIRECT(1'b0), .REFLECT_IN(1'b1), .REFLECT_OUT(1'b1)
  ) uut_alt (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(v1), .sof_i(s1), .data_i(d1),
    .ready_o(rdy1), .code_o(co1), .code_valid_o(cv1)
  );

  int vectors = 0, fails = 0;
  bit msg[64];
  bit got0[$], got1[$], exp0[$], exp1[$];
  int low0 = 0, low1 = 0, xlow0 = 0, xlow1 = 0;

  always @(negedge clk) begin
    if (cv0) got0.push_back(co0);
    if (cv1) got1.push_back(co1);
    if (rst_ni && !rdy0) low0++;
    if (rst_ni && !rdy1) low1++;
  end

  function automatic int rw(input int inst);  return inst == 0 ? 16 : 8; endfunction
  function automatic int nsub(input int inst); return inst == 0 ? 3 : 2; endfunction

  // expected checksum of the 16-bit subframe at msg[off]
  function automatic logic [15:0] model_crc(input int inst, input int off);
    logic [15:0] s, res;
    bit seq[32];
    bit gen[9];
    res = '0;
    if (inst == 0) begin
      s = 16'hFFFF;
      for (int i = 0; i < 16; i++) begin
        bit fb;
        fb = s[15] ^ msg[off+i];
        s = s << 1;
        if (fb) s = s ^ 16'h1021;
      end
      res = s ^ 16'h0F0F;
    end else begin
      for (int i = 0; i < 9; i++) gen[i] = (9'h107 >> i) & 1;
      for (int i = 0; i < 8; i++) seq[i] = (8'h5A >> (7 - i)) & 1;
      for (int k = 0; k < 2; k++)
        for (int j = 0; j < 8; j++) seq[8 + 8*k + j] = msg[off + 8*k + 7 - j];
      for (int i = 24; i < 32; i++) seq[i] = 0;
      for (int i = 0; i < 24; i++)
        if (seq[i]) for (int j = 0; j <= 8; j++) seq[i+j] ^= gen[8-j];
      // remainder bit order reversed (checksum reflection), then mask
      for (int i = 0; i < 8; i++) res[i] = seq[24+i];
      res = res ^ 16'h00A5;
    end
    return res;
  endfunction

  task automatic push_exp(input int inst, input bit b);
    if (inst == 0) exp0.push_back(b); else exp1.push_back(b);
  endtask

  task automatic send_bit(input int inst, input bit sof, input bit d);
    bit acc;
    if ($urandom_range(0, 3) == 0) @(negedge clk);
    if (inst == 0) begin v0 = 1; s0 = sof; d0 = d; end
    else           begin v1 = 1; s1 = sof; d1 = d; end
    do begin
      acc = (inst == 0) ? rdy0 : rdy1;
      @(negedge clk);
    end while (!acc);
    if (inst == 0) begin v0 = 0; s0 = 0; end
    else           begin v1 = 0; s1 = 0; end
  endtask

  task automatic send_frame(input int inst);
    int r, c;
    logic [15:0] ck;
    r = rw(inst); c = nsub(inst);
    for (int sb = 0; sb < c; sb++) begin
      for (int i = 0; i < 16; i++) begin
        send_bit(inst, (sb == 0 && i == 0), msg[sb*16+i]);
        push_exp(inst, msg[sb*16+i]);
      end
      ck = model_crc(inst, sb*16);
      for (int i = r - 1; i >= 0; i--) push_exp(inst, ck[i]);
      if (inst == 0) xlow0 += r; else xlow1 += r;
    end
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < 64; i++)
      msg[i] = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
  endtask

  task automatic check_stream(input int inst, input string tag);
    bit g[$], e[$];
    int bad, lo, xlo;
    repeat (24) @(negedge clk);
    if (inst == 0) begin g = got0; e = exp0; lo = low0; xlo = xlow0; end
    else           begin g = got1; e = exp1; lo = low1; xlo = xlow1; end
    vectors++;
    bad = -1;
    for (int i = 0; i < e.size() && i < g.size(); i++)
      if (bad < 0 && g[i] != e[i]) bad = i;
    if (g.size() != e.size() || bad >= 0) begin
      fails++;
      $display("FAIL %s: unit %0d got %0d bits exp %0d, first diff at %0d (got %0b exp %0b)",
               tag, inst, g.size(), e.size(), bad,
               (bad >= 0) ? g[bad] : 1'b0, (bad >= 0) ? e[bad] : 1'b0);
    end
    vectors++;
    if (lo != xlo) begin
      fails++;
      $display("FAIL R4 (%s): unit %0d ready low %0d cycles exp %0d", tag, inst, lo, xlo);
    end
    if (inst == 0) begin got0.delete(); exp0.delete(); low0 = 0; xlow0 = 0; end
    else           begin got1.delete(); exp1.delete(); low1 = 0; xlow1 = 0; end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    vectors++;
    if (cv0 !== 1'b0 || rdy0 !== 1'b1) begin
      fails++; $display("FAIL R1: unit 0 valid=%b ready=%b exp 0/1", cv0, rdy0);
    end
    vectors++;
    if (cv1 !== 1'b0 || rdy1 !== 1'b1) begin
      fails++; $display("FAIL R1: unit 1 valid=%b ready=%b exp 0/1", cv1, rdy1);
    end

    for (int i = 0; i < 5; i++) send_bit(0, 0, 1'($urandom_range(0, 1)));
    check_stream(0, "R10 bits before any start dropped");

    fill(0); send_frame(0); check_stream(0, "R2/R3/R5 all-zero frame");
    fill(1); send_frame(0); check_stream(0, "R5/R9 all-one frame");

    fill(2);
    for (int i = 16; i < 48; i++) msg[i] = msg[i-16];
    send_frame(0); check_stream(0, "R7 equal subframes");

    for (int n = 0; n < 4; n++) begin
      fill(2); send_frame(0); check_stream(0, "R2/R3/R5 random frame");
    end

    fill(2); send_frame(0);
    for (int i = 0; i < 3; i++) send_bit(0, 0, 1'b1);
    check_stream(0, "R12 bits after frame end dropped");

    fill(2);
    for (int i = 0; i < 10; i++) begin send_bit(0, (i == 0), msg[i]); push_exp(0, msg[i]); end
    fill(2); send_frame(0); check_stream(0, "R11 restart mid-subframe");

    fill(0); send_frame(1); check_stream(1, "R6/R9 indirect all-zero frame");
    fill(1); send_frame(1); check_stream(1, "R6/R8 indirect all-one frame");
    for (int n = 0; n < 4; n++) begin
      fill(2); send_frame(1); check_stream(1, "R6/R8/R9 indirect reflected random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule